// File: doc/BRIEF.md
# Packed-Syllable Stack Execution Unit

This unit runs a dense stack program in which every 16-bit halfword holds three 5-bit operation syllables. It keeps two independent last-in first-out stacks, one for fixed-point values and one for floating-point values. A current operand type decides which stack an operation uses and how fixed-point results are trimmed. Values enter a stack from an 8-entry general register file through a combinational read port. They leave it through a registered write port.

Halfwords arrive on a valid/ready stream. The unit takes one halfword when idle and then executes one syllable per clock. Three opcodes are prefixes whose operand is the following syllable: type select, register push and register pop. The two stack depths are exported as one packed pointer word. Floating-point arithmetic, division and the memory-addressed push/pop forms are not carried out here. Instead they raise sticky flags so that a neighbouring unit or trap handler can take over.

Top module: `stk_syllable_unit`

## Requirements
- R1: A halfword is accepted when `in_valid` and `in_ready` are both high. Its syllables are executed one per cycle in the order bits 15:11, 10:6, 5:1, and bit 0 has no effect. `in_ready` is high only when no halfword is held.
- R2: Opcode 00001 takes the next syllable as a type code in its low three bits: 0 byte (8 bits), 1 halfword (16), 2 integer (32), 3 long (64), 4 medium, 5 floating, 6 double, 7 quad. Codes 0 to 3 select the fixed-point stack and 4 to 7 the floating-point stack. After reset the type is long.
- R3: When a prefix opcode (00001, 11110, 11111) sits in the third syllable, its operand is the first syllable of the next accepted halfword.
- R4: On the selected stack, 00010 duplicates the top item and 00011 discards it. 01100 exchanges the top two items. 01101 moves the third item to the top and the old top two down one place.
- R5: With a fixed-point type, 00100, 00101 and 00110 replace the top two items with second+top, second-top and the low 64 bits of second*top. The result is truncated to the type width and sign-extended to 64 bits.
- R6: With a fixed-point type, 01000, 01001 and 01010 replace the top two items with their bitwise AND, OR and XOR, truncated and sign-extended as in R5.
- R7: 11110 followed by 0nnn0 pushes general register nnn unmodified. 11111 followed by 0nnn0 pops the top item into register nnn; `wr_en` pulses in the cycle after the pop executes.
- R8: `ptr_word` equals 256 times the fixed-point stack depth plus the floating-point stack depth, and each depth is a 6-bit count. Both depths are 0 after reset.
- R9: Each stack holds at most 63 items. A push or duplicate on a full stack, or an operation needing more items than present, sets sticky `err_stack` and leaves that stack's depth and contents unchanged.
- R10: Floating-type arithmetic (00100 to 01011), fixed-point divide (00111), 01011 with a fixed type, and the undefined codes 01110 to 11101 set sticky `err_unimpl` and change no stack.
- R11: A push or pop prefix whose operand syllable has bit 4 or bit 0 set sets sticky `err_escape`, changes no stack, and discards the rest of the halfword in which that operand syllable lies.
- R12: 00000 changes no stack, no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Halfword offered |
| in_hw | input | 16 | Packed three-syllable halfword |
| in_ready | output | 1 | Unit can take a halfword |
| busy | output | 1 | Halfword in execution or register write pending |
| rd_idx | output | 3 | General register read index |
| rd_data | input | 64 | Register value for `rd_idx`, same cycle |
| wr_en | output | 1 | General register write strobe |
| wr_idx | output | 3 | General register write index |
| wr_data | output | 64 | General register write value |
| ptr_word | output | 16 | Packed stack depths (fixed*256 + float) |
| err_stack | output | 1 | Sticky stack overflow/underflow flag |
| err_unimpl | output | 1 | Sticky unimplemented operation flag |
| err_escape | output | 1 | Sticky memory-addressed push/pop flag |

## Verification
The assertions assume that `rd_data` presents the addressed register in the same cycle that `rd_idx` points at it. They also assume reset is applied before the first halfword. The bench meets both by modelling the register file with a combinational read. It offers a halfword only at a falling edge while `in_ready` is high. Register preloads and pop results share one bench-side write process, so register contents never race the unit's writes.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int DW = 64;

  typedef enum logic [2:0] {
    SC_NONE, SC_PUSH, SC_POP, SC_DUP, SC_DROP, SC_SWAP, SC_ROT, SC_BIN
  } scmd_e;

  typedef enum logic [1:0] {PD_NONE, PD_TYPE, PD_PUSHR, PD_POPR} pend_e;

  localparam logic [4:0] OPC_NOP   = 5'b00000;
  localparam logic [4:0] OPC_TYPE  = 5'b00001;
  localparam logic [4:0] OPC_DUP   = 5'b00010;
  localparam logic [4:0] OPC_DROP  = 5'b00011;
  localparam logic [4:0] OPC_ADD   = 5'b00100;
  localparam logic [4:0] OPC_SUB   = 5'b00101;
  localparam logic [4:0] OPC_MUL   = 5'b00110;
  localparam logic [4:0] OPC_AND   = 5'b01000;
  localparam logic [4:0] OPC_OR    = 5'b01001;
  localparam logic [4:0] OPC_XOR   = 5'b01010;
  localparam logic [4:0] OPC_SWAP  = 5'b01100;
  localparam logic [4:0] OPC_ROT   = 5'b01101;
  localparam logic [4:0] OPC_PUSHR = 5'b11110;
  localparam logic [4:0] OPC_POPR  = 5'b11111;

  // trim a value to the width of fixed type ty, then sign-extend
  function automatic logic [DW-1:0] sext_ty(input logic [DW-1:0] v, input logic [2:0] ty);
    case (ty[1:0])
      2'd0:    return {{(DW-8){v[7]}}, v[7:0]};
      2'd1:    return {{(DW-16){v[15]}}, v[15:0]};
      2'd2:    return {{(DW-32){v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [DW-1:0] alu_fix(input logic [4:0] op, input logic [DW-1:0] a,
                                            input logic [DW-1:0] b, input logic [2:0] ty);
    logic [DW-1:0] r;
    case (op)
      OPC_ADD: r = a + b;
      OPC_SUB: r = a - b;
      OPC_MUL: r = a * b;
      OPC_AND: r = a & b;
      OPC_OR:  r = a | b;
      OPC_XOR: r = a ^ b;
      default: r = '0;
    endcase
    return sext_ty(r, ty);
  endfunction
endpackage

// File: rtl/stk_fixalu.sv
module stk_fixalu
  import stk_pkg::*;
(
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] sec_i,
  input  logic [DW-1:0] top_i,
  input  logic [2:0]    ty_i,
  output logic [DW-1:0] res_o
);
  always_comb res_o = alu_fix(op_i, sec_i, top_i, ty_i);
endmodule

// File: rtl/stk_lifo.sv
module stk_lifo
  import stk_pkg::*;
#(
  parameter int W  = 64,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  scmd_e         cmd_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  top_o,
  output logic [W-1:0]  sec_o,
  output logic [PW-1:0] cnt_o,
  output logic          err_o
);
  localparam int N = 1 << PW;
  localparam logic [PW-1:0] CAP = PW'(N - 1);

  logic [W-1:0]  mem [N];
  logic [PW-1:0] cnt_q, i1, i2, i3;
  logic [W-1:0]  thr;
  logic          upd;

  assign i1    = cnt_q - PW'(1);
  assign i2    = cnt_q - PW'(2);
  assign i3    = cnt_q - PW'(3);
  assign top_o = mem[i1];
  assign sec_o = mem[i2];
  assign thr   = mem[i3];
  assign cnt_o = cnt_q;

  always_comb begin
    case (cmd_i)
      SC_PUSH:           err_o = (cnt_q == CAP);
      SC_DUP:            err_o = (cnt_q == CAP) || (cnt_q < PW'(1));
      SC_POP, SC_DROP:   err_o = (cnt_q < PW'(1));
      SC_SWAP, SC_BIN:   err_o = (cnt_q < PW'(2));
      SC_ROT:            err_o = (cnt_q < PW'(3));
      default:           err_o = 1'b0;
    endcase
  end
  assign upd = (cmd_i != SC_NONE) && !err_o;

  always_ff @(posedge clk) begin
    if (upd) begin
      case (cmd_i)
        SC_PUSH: mem[cnt_q] <= wdata_i;
        SC_DUP:  mem[cnt_q] <= top_o;
        SC_SWAP: begin mem[i1] <= sec_o; mem[i2] <= top_o; end
        SC_ROT:  begin mem[i1] <= thr; mem[i2] <= top_o; mem[i3] <= sec_o; end
        SC_BIN:  mem[i2] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (upd) begin
      case (cmd_i)
        SC_PUSH, SC_DUP:         cnt_q <= cnt_q + PW'(1);
        SC_POP, SC_DROP, SC_BIN: cnt_q <= cnt_q - PW'(1);
        default: ;
      endcase
    end
  end

  // R9: a rejected operation leaves the depth alone
  a_r9_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(cnt_q));
  // R7: an accepted push deepens the stack by exactly one
  a_r7_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == SC_PUSH && !err_o) |=> (cnt_q == $past(cnt_q) + PW'(1)));
endmodule

// File: rtl/stk_syllable_unit.sv
module stk_syllable_unit
  import stk_pkg::*;
#(
  parameter int PW = 6,
  parameter int RI = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_hw,
  output logic          in_ready,
  output logic          busy,
  output logic [RI-1:0] rd_idx,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [RI-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic [15:0]   ptr_word,
  output logic          err_stack,
  output logic          err_unimpl,
  output logic          err_escape
);
  localparam int NSTK = 2;   // 0 fixed-point, 1 floating-point

  logic [15:0]   hw_q;
  logic          have;
  logic [1:0]    slot;
  pend_e         pend_q, pend_n;
  logic [2:0]    ty_q;
  logic [4:0]    syl;
  logic          sel;
  scmd_e         cmd;
  logic [DW-1:0] wdata, alu_res;
  logic          unimpl_ev, esc_ev, pop_ev, type_ev, stk_ev;
  logic          unused_bit0;

  scmd_e         cmd_v [NSTK];
  logic [DW-1:0] top_v [NSTK];
  logic [DW-1:0] sec_v [NSTK];
  logic [PW-1:0] cnt_v [NSTK];
  logic          err_v [NSTK];

  assign unused_bit0 = hw_q[0];
  assign sel = ty_q[2];

  always_comb begin
    case (slot)
      2'd0:    syl = hw_q[15:11];
      2'd1:    syl = hw_q[10:6];
      default: syl = hw_q[5:1];
    endcase
  end

  for (genvar g = 0; g < NSTK; g++) begin : g_stk
    assign cmd_v[g] = (sel == 1'(g)) ? cmd : SC_NONE;
    stk_lifo #(.W(DW), .PW(PW)) u_lifo (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_v[g]), .wdata_i(wdata),
      .top_o(top_v[g]), .sec_o(sec_v[g]), .cnt_o(cnt_v[g]), .err_o(err_v[g]));
  end

  stk_fixalu u_alu (.op_i(syl), .sec_i(sec_v[sel]), .top_i(top_v[sel]),
                    .ty_i(ty_q), .res_o(alu_res));

  assign rd_idx = syl[3:1];
  assign stk_ev = err_v[0] | err_v[1];

  always_comb begin
    cmd = SC_NONE; wdata = '0; pend_n = PD_NONE;
    unimpl_ev = 1'b0; esc_ev = 1'b0; pop_ev = 1'b0; type_ev = 1'b0;
    if (have) begin
      if (pend_q != PD_NONE) begin
        if (pend_q == PD_TYPE) type_ev = 1'b1;
        else if (syl[4] || syl[0]) esc_ev = 1'b1;
        else if (pend_q == PD_PUSHR) begin cmd = SC_PUSH; wdata = rd_data; end
        else begin cmd = SC_POP; pop_ev = 1'b1; end
      end else begin
        case (syl)
          OPC_NOP:   ;
          OPC_TYPE:  pend_n = PD_TYPE;
          OPC_PUSHR: pend_n = PD_PUSHR;
          OPC_POPR:  pend_n = PD_POPR;
          OPC_DUP:   cmd = SC_DUP;
          OPC_DROP:  cmd = SC_DROP;
          OPC_SWAP:  cmd = SC_SWAP;
          OPC_ROT:   cmd = SC_ROT;
          OPC_ADD, OPC_SUB, OPC_MUL, OPC_AND, OPC_OR, OPC_XOR:
            if (!sel) begin cmd = SC_BIN; wdata = alu_res; end
            else unimpl_ev = 1'b1;
          default:   unimpl_ev = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_q <= '0; have <= 1'b0; slot <= '0; pend_q <= PD_NONE; ty_q <= 3'd3;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      err_stack <= 1'b0; err_unimpl <= 1'b0; err_escape <= 1'b0;
    end else begin
      wr_en <= pop_ev && !stk_ev;
      if (pop_ev) begin wr_idx <= syl[3:1]; wr_data <= top_v[sel]; end
      if (type_ev) ty_q <= syl[2:0];
      if (stk_ev)    err_stack  <= 1'b1;
      if (unimpl_ev) err_unimpl <= 1'b1;
      if (esc_ev)    err_escape <= 1'b1;
      if (!have) begin
        if (in_valid) begin hw_q <= in_hw; have <= 1'b1; slot <= '0; end
      end else begin
        pend_q <= pend_n;
        if (slot == 2'd2 || esc_ev) begin have <= 1'b0; slot <= '0; end
        else slot <= slot + 2'd1;
      end
    end
  end

  assign in_ready = !have;
  assign busy     = have | wr_en;
  assign ptr_word = (16'(cnt_v[0]) << 8) | 16'(cnt_v[1]);

  // R1: an accepted halfword keeps the unit busy in the next cycle
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R2: at most one stack receives a command per cycle
  a_r2_one_stack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_v[0] != SC_NONE, cmd_v[1] != SC_NONE}));
  // R7: a register write only follows a cycle that was executing
  a_r7_write_after_exec: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(have));
  // R9: the stack error flag never clears outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_stack |=> err_stack);
  // R11: an escape ends the current halfword
  a_r11_escape_discard: assert property (@(posedge clk) disable iff (!rst_n)
    esc_ev |=> in_ready);
endmodule

// File: tb/tb_stk_syllable_unit.sv
module tb_stk_syllable_unit;
  logic        clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [15:0] in_hw = '0;
  logic        in_ready, busy, wr_en, err_stack, err_unimpl, err_escape;
  logic [2:0]  rd_idx, wr_idx;
  logic [63:0] rd_data, wr_data;
  logic [15:0] ptr_word;
  logic [63:0] rf [8];
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [63:0] ld_val = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stk_syllable_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hw(in_hw),
    .in_ready(in_ready), .busy(busy), .rd_idx(rd_idx), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr_word(ptr_word),
    .err_stack(err_stack), .err_unimpl(err_unimpl), .err_escape(err_escape));

  assign rd_data = rf[rd_idx];
  always @(posedge clk) begin
    if (wr_en) rf[wr_idx] <= wr_data;
    if (ld_en) rf[ld_idx] <= ld_val;
  end

  localparam logic [4:0] NOP = 5'b00000, TYP = 5'b00001, DUP = 5'b00010, DRP = 5'b00011,
    DIV = 5'b00111, SWP = 5'b01100, ROT = 5'b01101, PSH = 5'b11110, POP = 5'b11111,
    ADD = 5'b00100;

  function automatic logic [15:0] mk(logic [4:0] a, logic [4:0] b, logic [4:0] c);
    return {a, b, c, 1'b0};
  endfunction
  function automatic logic [4:0] rg(int n);
    return {1'b0, 3'(n), 1'b0};
  endfunction
  function automatic logic [63:0] expect_alu(int k, logic [63:0] a, logic [63:0] b, int t);
    logic [63:0] raw;
    logic signed [63:0] s;
    int sh;
    case (k)
      0: raw = a + b;  1: raw = a - b;  2: raw = a * b;
      3: raw = a & b;  4: raw = a | b;  default: raw = a ^ b;
    endcase
    sh = 64 - (8 << t);
    s = raw << sh;
    return s >>> sh;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic send(logic [15:0] h);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_hw = h;
    @(negedge clk);
    in_valid = 1'b0;
  endtask
  task automatic drain();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask
  task automatic setr(int i, logic [63:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 3'(i); ld_val = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask
  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] va [4];
    logic [63:0] vb [4];
    logic [4:0]  ops [6];
    va[0] = 64'h7F;                  vb[0] = 64'h1;
    va[1] = 64'hFFFF_FFFF_FFFF_FF80; vb[1] = 64'h3;
    va[2] = 64'h1234_5678_9ABC_DEF0; vb[2] = 64'h0FED_CBA9_8765_4321;
    va[3] = 64'h8000_0000;           vb[3] = 64'hFFFF_FFFF;
    ops[0] = 5'b00100; ops[1] = 5'b00101; ops[2] = 5'b00110;
    ops[3] = 5'b01000; ops[4] = 5'b01001; ops[5] = 5'b01010;
    for (int i = 0; i < 8; i++) rf[i] = '0;

    // reset state (R8, R1)
    do_reset();
    check("R8 reset ptr_word", ptr_word, 16'h0);
    check("R1 reset ready", {in_ready, busy}, 2'b10);
    check("R9 reset flags", {err_stack, err_unimpl, err_escape}, 3'b000);

    // R5 R6: fixed-point sweep over types, operations and operand pairs
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 6; k++)
        for (int p = 0; p < 4; p++) begin
          do_reset();
          setr(1, va[p]); setr(2, vb[p]); setr(3, 64'hDEAD);
          send(mk(TYP, 5'(t), NOP));
          send(mk(PSH, rg(1), PSH));
          send(mk(rg(2), ops[k], POP));
          send(mk(rg(3), NOP, NOP));
          drain();
          check(k < 3 ? "R5 arith result" : "R6 logic result", rf[3],
                expect_alu(k, va[p], vb[p], t));
          check("R8 stack empty after pop", ptr_word, 16'h0);
        end

    // R4 ROT, with R7 pushes and pops
    do_reset();
    setr(1, 11); setr(2, 22); setr(3, 33);
    send(mk(PSH, rg(1), PSH)); send(mk(rg(2), PSH, rg(3)));
    send(mk(ROT, POP, rg(4))); send(mk(POP, rg(5), POP)); send(mk(rg(6), NOP, NOP));
    drain();
    check("R4 rot new top", rf[4], 64'd11);
    check("R4 rot second", rf[5], 64'd33);
    check("R4 rot bottom", rf[6], 64'd22);

    // R4 SWAP and DUP
    do_reset();
    send(mk(PSH, rg(1), PSH)); send(mk(rg(2), SWP, DUP));
    drain();
    check("R4 depth after dup", ptr_word, 16'h0300);
    send(mk(POP, rg(4), POP)); send(mk(rg(5), POP, rg(6)));
    drain();
    check("R4 swap/dup top", rf[4], 64'd11);
    check("R4 dup copy", rf[5], 64'd11);
    check("R4 swap bottom", rf[6], 64'd22);

    // R4 DROP
    do_reset();
    send(mk(PSH, rg(1), PSH)); send(mk(rg(2), DRP, POP)); send(mk(rg(4), NOP, NOP));
    drain();
    check("R4 drop leaves lower", rf[4], 64'd11);
    check("R4 drop depth", ptr_word, 16'h0);

    // R2 R8 float stack selection, R10 float arithmetic
    do_reset();
    send(mk(TYP, 5'b00101, PSH)); send(mk(rg(1), TYP, 5'b00011));
    send(mk(PSH, rg(2), NOP));
    drain();
    check("R2 R8 one per stack", ptr_word, 16'h0101);
    send(mk(PSH, rg(1), PSH)); send(mk(rg(2), NOP, NOP));
    drain();
    check("R8 packed depths", ptr_word, 16'h0301);
    send(mk(TYP, 5'b00110, PSH)); send(mk(rg(1), ADD, NOP));
    drain();
    check("R10 float add unimpl", err_unimpl, 1'b1);
    check("R10 float add no stack change", ptr_word, 16'h0302);

    // R10 fixed divide and undefined code
    do_reset();
    send(mk(PSH, rg(1), PSH)); send(mk(rg(2), DIV, NOP));
    drain();
    check("R10 divide unimpl", err_unimpl, 1'b1);
    check("R10 divide no stack change", ptr_word, 16'h0200);
    do_reset();
    send(mk(5'b01110, NOP, NOP));
    drain();
    check("R10 undefined code", {err_unimpl, ptr_word}, {1'b1, 16'h0});

    // R3 prefixes in the third syllable
    do_reset();
    send(mk(NOP, NOP, TYP)); send(mk(5'b00101, PSH, rg(1)));
    drain();
    check("R3 type operand carried", ptr_word, 16'h0001);
    send(mk(NOP, NOP, PSH)); send(mk(rg(2), NOP, NOP));
    drain();
    check("R3 push operand carried", ptr_word, 16'h0002);

    // R1 bit 0 ignored
    do_reset();
    send(mk(PSH, rg(1), NOP) | 16'h1);
    drain();
    check("R1 bit0 ignored", ptr_word, 16'h0100);

    // R12 NOP
    send(mk(NOP, NOP, NOP));
    drain();
    check("R12 nop no change", {ptr_word, err_stack, err_unimpl, err_escape}, {16'h0100, 3'b000});

    // R9 underflow
    do_reset();
    setr(4, 64'hBEEF);
    send(mk(POP, rg(4), NOP));
    drain();
    check("R9 pop empty flag", err_stack, 1'b1);
    check("R9 pop empty register kept", rf[4], 64'hBEEF);
    check("R9 pop empty depth", ptr_word, 16'h0);

    // R9 overflow at 63 items
    do_reset();
    setr(1, 64'h77);
    for (int n = 0; n < 63; n++) send(mk(PSH, rg(1), NOP));
    drain();
    check("R9 full no error", {err_stack, ptr_word}, {1'b0, 16'h3F00});
    send(mk(PSH, rg(1), DUP));
    drain();
    check("R9 overflow flag", err_stack, 1'b1);
    check("R9 overflow depth kept", ptr_word, 16'h3F00);

    // R11 escape forms
    do_reset();
    send(mk(PSH, 5'b10000, PSH)); send(mk(NOP, NOP, NOP));
    drain();
    check("R11 escape flag", err_escape, 1'b1);
    check("R11 rest discarded", ptr_word, 16'h0);
    do_reset();
    send(mk(POP, 5'b00011, NOP));
    drain();
    check("R11 pop escape", {err_escape, err_stack}, 2'b10);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule